// File: doc/BRIEF.md
# ASK Infrared Carrier Generator

This block produces the carrier used for amplitude-shift-keyed infrared transmission. It divides the master clock by a programmable divider value plus two. The master clock is nominally 3.6864 MHz, so the carrier frequency is 3.6864 MHz / (MD + 2). Software loads the divider value MD as two bytes. The low byte holds bits 7:0 and the high byte holds the bits from 8 upwards.

The carrier is gated by the transmit data line. While that line is high, the LED drive pulses at the carrier rate. While it is low, the LED drive stays off. Each time transmission starts, the carrier restarts at the beginning of its high phase. A registered copy of the transmit gate is exported so that receive blanking logic knows when the LED may be lit.

A divider change written during transmission waits for the current carrier period to end. This means no shortened or stretched pulse is ever emitted. The reset divider value is 5, which gives about 527 kHz.

Top module: `ask_carrier_gen`

## Requirements
- R1: After reset, MD is MD_RST (default 5), led_o and led_active_o are 0, and carrier_o is 1.
- R2: While transmitting, carrier_o and led_o repeat with a period of exactly MD + 2 clock cycles.
- R3: Each period starts with floor((MD + 2) / 2) high cycles, and the remaining cycles of the period are low.
- R4: A clock edge with md_lo_we_i high loads md_wdata_i into MD[7:0]. A clock edge with md_hi_we_i high loads md_wdata_i[MD_W-9:0] into MD[MD_W-1:8]. Data bits above the register width are ignored.
- R5: A new MD written during transmission first takes effect in the period that follows the current one. The period in progress completes with the old value.
- R6: While the registered transmit gate is low, led_o is 0 and carrier_o is held at 1 (the start of the high phase).
- R7: The first clock edge that samples tx_i high starts a new period at its first high cycle, using the MD value present at that edge.
- R8: led_active_o equals the value of tx_i sampled at the previous clock edge.
- R9: led_o is high exactly when led_active_o and carrier_o are both high.
- R10: The largest MD value, 2^MD_W - 1, gives a period of 2^MD_W + 1 cycles with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| md_lo_we_i | input | 1 | Write strobe for divider bits 7:0 |
| md_hi_we_i | input | 1 | Write strobe for divider bits MD_W-1:8 |
| md_wdata_i | input | 8 | Divider byte to be written |
| tx_i | input | 1 | Transmit data; high sends light pulses |
| carrier_o | output | 1 | Carrier waveform |
| led_o | output | 1 | Gated LED drive |
| led_active_o | output | 1 | Transmit gate status, used for receive blanking |

## Verification
The bench builds the block with MD_W = 10 and MD_RST = 5. The narrow divider brings the largest value, a 1025-cycle period, within a short run. It also means the high-byte write carries unused data bits that must be dropped. The bench measures divider values 0, 1, 5, 20, 301 and 1023. These cover both odd and even periods and the shortest possible period of two cycles. A behavioural model is compared on every cycle, including divider writes that land mid-period and transmit toggles that land at random points in the period.

// File: rtl/ask_pkg.sv
package ask_pkg;
  localparam int unsigned ASK_MD_W_DEF   = 16;
  localparam int unsigned ASK_MD_RST_DEF = 5;
endpackage

// File: rtl/ask_md_regs.sv
module ask_md_regs #(
  parameter int unsigned MD_W   = ask_pkg::ASK_MD_W_DEF,
  parameter int unsigned MD_RST = ask_pkg::ASK_MD_RST_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [7:0]      wdata_i,
  output logic [MD_W-1:0] md_o
);
  localparam int unsigned HI_W = MD_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= MD_RST[7:0];
      hi_q <= HI_W'(MD_RST >> 8);
    end else begin
      if (lo_we_i) lo_q <= wdata_i;
      if (hi_we_i) hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign md_o = {hi_q, lo_q};

  p_lo_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> md_o[7:0] == $past(wdata_i));
  p_hi_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> md_o[MD_W-1:8] == $past(wdata_i[HI_W-1:0]));
endmodule

// File: rtl/ask_div.sv
module ask_div #(
  parameter int unsigned MD_W   = ask_pkg::ASK_MD_W_DEF,
  parameter int unsigned MD_RST = ask_pkg::ASK_MD_RST_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_i,
  input  logic            run_i,
  input  logic [MD_W-1:0] md_pend_i,
  output logic            carrier_o
);
  localparam int unsigned P_W = MD_W + 1;

  logic [MD_W-1:0] md_act_q;
  logic [P_W-1:0]  cnt_q;
  logic [P_W-1:0]  period;
  logic [P_W-1:0]  half;
  logic            wrap;

  assign period = {1'b0, md_act_q} + P_W'(2);
  assign half   = period >> 1;
  assign wrap   = (cnt_q == period - P_W'(1));

  // idle or start: hold at phase 0 and track pending divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      md_act_q <= MD_W'(MD_RST);
    end else if (!tx_i || !run_i || wrap) begin
      cnt_q    <= '0;
      md_act_q <= md_pend_i;
    end else begin
      cnt_q <= cnt_q + P_W'(1);
    end
  end

  assign carrier_o = (cnt_q < half);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period);
  p_md_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != '0) |-> md_act_q == $past(md_act_q));
  p_restart_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0 && carrier_o));
  p_idle_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> carrier_o);
endmodule

// File: rtl/ask_gate.sv
module ask_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_i,
  input  logic carrier_i,
  output logic run_o,
  output logic led_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_o <= 1'b0;
    else         run_o <= tx_i;
  end

  assign led_o = run_o & carrier_i;

  p_led_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> !led_o);
  p_run_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> run_o == $past(tx_i));
endmodule

// File: rtl/ask_carrier_gen.sv
module ask_carrier_gen #(
  parameter int unsigned MD_W   = ask_pkg::ASK_MD_W_DEF,
  parameter int unsigned MD_RST = ask_pkg::ASK_MD_RST_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       md_lo_we_i,
  input  logic       md_hi_we_i,
  input  logic [7:0] md_wdata_i,
  input  logic       tx_i,
  output logic       carrier_o,
  output logic       led_o,
  output logic       led_active_o
);
  logic [MD_W-1:0] md_pend;
  logic            run;

  ask_md_regs #(.MD_W(MD_W), .MD_RST(MD_RST)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (md_lo_we_i),
    .hi_we_i (md_hi_we_i),
    .wdata_i (md_wdata_i),
    .md_o    (md_pend)
  );

  ask_div #(.MD_W(MD_W), .MD_RST(MD_RST)) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_i      (tx_i),
    .run_i     (run),
    .md_pend_i (md_pend),
    .carrier_o (carrier_o)
  );

  ask_gate i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_i      (tx_i),
    .carrier_i (carrier_o),
    .run_o     (run),
    .led_o     (led_o)
  );

  assign led_active_o = run;

  p_led_and_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == (led_active_o && carrier_o));
endmodule

// File: tb/test_ask_carrier_gen.sv
module test_ask_carrier_gen;
  localparam int MD_W = 10;
  localparam int MAXMD = (1 << MD_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_we = 1'b0, hi_we = 1'b0, tx = 1'b0;
  logic [7:0] wdata = '0;
  logic carrier, led, led_act;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_pend = 5, m_act = 5, m_cnt = 0;
  bit m_run = 0;

  always #2 clk = ~clk;

  ask_carrier_gen #(.MD_W(MD_W), .MD_RST(5)) i_ask_carrier_gen (
    .clk_i(clk), .rst_ni(rst_n), .md_lo_we_i(lo_we), .md_hi_we_i(hi_we),
    .md_wdata_i(wdata), .tx_i(tx), .carrier_o(carrier), .led_o(led),
    .led_active_o(led_act)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (!tx || !m_run || m_cnt == m_act + 1) begin
        m_cnt <= 0;
        m_act <= m_pend;
      end else m_cnt <= m_cnt + 1;
      m_run <= tx;
      if (lo_we) m_pend <= (m_pend & ~255) | int'(wdata);
      if (hi_we) m_pend <= (m_pend & 255) | ((int'(wdata) << 8) & MAXMD & ~255);
      if (lo_we && hi_we) m_pend <= int'(wdata) | ((int'(wdata) << 8) & MAXMD & ~255);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_car;
      m_car = (m_cnt < (m_act + 2) / 2);
      chk("R2 R3 R5 R7 carrier_o", int'(carrier), int'(m_car));
      chk("R6 R9 led_o", int'(led), int'(m_run && m_car));
      chk("R8 led_active_o", int'(led_act), int'(m_run));
    end
  end

  task automatic write_md(input int md);
    @(negedge clk);
    lo_we = 1; wdata = md[7:0];
    @(negedge clk);
    lo_we = 0; hi_we = 1; wdata = md[15:8];
    @(negedge clk);
    hi_we = 0;
  endtask

  // start transmit and measure first period at the LED
  task automatic measure(input string req, input int md);
    int h, l;
    @(negedge clk); tx = 0;
    write_md(md);
    tx = 1;
    @(negedge clk);
    h = 0; l = 0;
    while (led && h < 3000) begin h++; @(negedge clk); end
    while (!led && l < 3000) begin l++; @(negedge clk); end
    chk({req, " high"}, h, (md + 2) / 2);
    chk({req, " period"}, h + l, md + 2);
    tx = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 led_o", int'(led), 0);
    chk("R1 led_active_o", int'(led_act), 0);
    chk("R1 carrier_o", int'(carrier), 1);
    rst_n = 1;
    @(negedge clk);
    tx = 1;
    @(negedge clk);
    begin
      int h = 0, l = 0;
      while (led) begin h++; @(negedge clk); end
      while (!led) begin l++; @(negedge clk); end
      chk("R1 default period", h + l, 7);
      chk("R1 default high", h, 3);
    end
    tx = 0;
    repeat (3) @(negedge clk);
    chk("R6 idle led_o", int'(led), 0);
    chk("R6 idle carrier_o", int'(carrier), 1);

    measure("R2 R3 md=0", 0);
    measure("R2 R3 md=1", 1);
    measure("R2 R3 md=20", 20);
    measure("R2 R3 md=301", 301);
    measure("R10 md=max", MAXMD);

    // R4: high byte with unused bits set
    @(negedge clk);
    hi_we = 1; wdata = 8'hFD;
    @(negedge clk);
    hi_we = 0; lo_we = 1; wdata = 8'h03;
    @(negedge clk);
    lo_we = 0;
    tx = 1;
    @(negedge clk);
    begin
      int h = 0, l = 0;
      while (led) begin h++; @(negedge clk); end
      while (!led) begin l++; @(negedge clk); end
      chk("R4 upper bits dropped period", h + l, 256 + 3 + 2);
    end

    // R5: change divider mid-period while transmitting
    write_md(10);
    repeat (5) @(negedge clk);
    write_md(40);
    repeat (300) @(negedge clk);
    write_md(3);
    repeat (100) @(negedge clk);

    // R7: random tx toggles
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tx = ($urandom_range(0, 9) != 0) ? tx : ~tx;
      if ($urandom_range(0, 49) == 0) begin
        lo_we = 1; wdata = 8'($urandom_range(0, 12));
      end else lo_we = 0;
    end
    lo_we = 0; tx = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule